// File: doc/BRIEF.md
# Serial Frame Transmitter with Fractional Baud Timing

This block turns a byte into an asynchronous serial frame on a single output line. Software, or a neighbouring control block, writes three setup values through one write port: a line-format word, an integer divisor and a 3-bit fraction. It then writes the byte to send through the same port. The block builds the frame from a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit and one or two high stop bits. The line rests high between frames.

Each bit is divided into 16 sub-periods. A sub-period is normally divisor+1 clocks long. The first `fraction` sub-periods of each bit are one clock longer, so a bit lasts 16×divisor + fraction + 16 clocks and the fractional part is spread across the bit rather than added at its end. The format and timing are captured when a byte is accepted, so setup writes made during a frame affect only later frames. Two empty flags report when the transmitter is idle. A sticky drop flag records a byte the block could not take.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line output is high, both empty flags read 1 and the drop flag reads 0.
- R2: The data width is line-format bits [1:0] plus 5. A frame starts with one low bit, followed by the data bits least significant first.
- R3: Line-format bit 2 set gives two high stop bits; clear gives one.
- R4: Line-format bit 5 set inserts a parity bit right after the last data bit. Line-format bit 3 set gives even parity (the data bits and the parity bit hold an even number of ones). Clear gives odd parity. Bit 4 has no effect.
- R5: Every bit of a frame lasts exactly 16×D + F + 16 clocks, where D is the divisor and F is fraction bits [2:0]. The first F of the 16 sub-periods are one clock longer than the other sub-periods.
- R6: Both empty flags drop to 0 on the clock edge that accepts a byte and stay 0 for 1 + data + parity + stop bit periods. They return to 1 on the next edge, with the line high.
- R7: While the divisor is zero, a data write is ignored: the line stays high, the empty flags stay 1, and the drop flag is set.
- R8: A data write while a frame is in progress does not alter that frame and sets the drop flag. The drop flag stays set until the next accepted data write clears it.
- R9: Line-format, divisor and fraction writes made during a frame take effect from the next accepted byte.
- R10: Write select codes: 0 line format (data bits [5:0]), 1 divisor (all bits), 2 fraction (bits [2:0]), 3 transmit byte (bits [7:0]).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_sel | input | 2 | Register select (see R10) |
| wr_data | input | DIV_W | Write value |
| tx_out | output | 1 | Serial line, idle high |
| tx_empty | output | 1 | Transmitter idle |
| buf_empty | output | 1 | Ready to take a byte |
| drop_flag | output | 1 | Sticky: a byte was refused |

## Verification
Frames are sent with every combination of data width, stop count and parity setting. Bytes of all zeros and all ones separate the parity sense and the bit order. Random bytes catch misplaced or swapped data bits. The line is sampled in the middle of each bit, and the flags are sampled on the last and first cycle around the frame end. Together these checks show the bit period is exact for each divisor and fraction, not merely close. Injected writes during a frame, and a write with the divisor at zero, separate a refused byte from a corrupted frame. They also show whether setup registers are captured at frame start.

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [DIV_W-1:0] wr_data,
  output logic             tx_out,
  output logic             tx_empty,
  output logic             buf_empty,
  output logic             drop_flag
);
  localparam int FRM_W = 12;
  localparam int SUB_W = DIV_W + 1;

  logic [5:0]       fmt_q;
  logic [DIV_W-1:0] div_q, cdiv_q;
  logic [2:0]       frac_q, cfrac_q;
  logic             busy_q, drop_q;
  logic [FRM_W-1:0] sh_q;
  logic [3:0]       nbits_q, bit_q, tick_q;
  logic [SUB_W-1:0] sub_q;

  logic             data_wr, accept;
  logic [3:0]       dbits, nbits_new;
  logic             par;
  logic [FRM_W-1:0] frame;
  logic [SUB_W-1:0] sub_end;

  assign data_wr = wr_en && (wr_sel == 2'd3);
  assign accept  = data_wr && !busy_q && (div_q != '0);
  assign dbits   = {2'b00, fmt_q[1:0]} + 4'd5;
  assign nbits_new = 4'd1 + dbits + {3'b000, fmt_q[5]} + (fmt_q[2] ? 4'd2 : 4'd1);

  always_comb begin
    par   = 1'b0;
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < int'(dbits)) begin
        frame[i+1] = wr_data[i];
        par = par ^ wr_data[i];
      end
    end
    if (fmt_q[5]) frame[dbits+4'd1] = fmt_q[3] ? par : ~par;
  end

  assign sub_end = {1'b0, cdiv_q} + ((tick_q < {1'b0, cfrac_q}) ? SUB_W'(1) : SUB_W'(0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q   <= '0;
      div_q   <= '0;
      frac_q  <= '0;
      cdiv_q  <= '0;
      cfrac_q <= '0;
      busy_q  <= 1'b0;
      drop_q  <= 1'b0;
      sh_q    <= '1;
      nbits_q <= '0;
      bit_q   <= '0;
      tick_q  <= '0;
      sub_q   <= '0;
    end else begin
      if (wr_en) begin
        case (wr_sel)
          2'd0: fmt_q  <= wr_data[5:0];
          2'd1: div_q  <= wr_data;
          2'd2: frac_q <= wr_data[2:0];
          default: ;
        endcase
      end
      if (accept) begin
        busy_q  <= 1'b1;
        drop_q  <= 1'b0;
        sh_q    <= frame;
        nbits_q <= nbits_new;
        bit_q   <= '0;
        tick_q  <= '0;
        sub_q   <= '0;
        cdiv_q  <= div_q;
        cfrac_q <= frac_q;
      end else begin
        if (data_wr) drop_q <= 1'b1;
        if (busy_q) begin
          if (sub_q == sub_end) begin
            sub_q  <= '0;
            tick_q <= tick_q + 4'd1;
            if (tick_q == 4'd15) begin
              sh_q <= {1'b1, sh_q[FRM_W-1:1]};
              if (bit_q == nbits_q - 4'd1) busy_q <= 1'b0;
              else bit_q <= bit_q + 4'd1;
            end
          end else begin
            sub_q <= sub_q + SUB_W'(1);
          end
        end
      end
    end
  end

  assign tx_out    = busy_q ? sh_q[0] : 1'b1;
  assign tx_empty  = !busy_q;
  assign buf_empty = !busy_q;
  assign drop_flag = drop_q;

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !tx_out);
  // R5
  sub_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (sub_q <= sub_end));
  // R6
  bit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (bit_q < nbits_q));
  // R6
  flag_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty == buf_empty);
  // R7
  div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0) && tx_empty |=> tx_empty);
  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && busy_q |=> drop_flag && !tx_empty);
  // R9
  hold_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && $past(busy_q) |-> $stable(cdiv_q) && $stable(cfrac_q));
endmodule

// File: tb/uart_frame_tx_tb.sv
`timescale 1ns/1ps
module uart_frame_tx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = '0;
  logic        tx_out, tx_empty, buf_empty, drop_flag;
  int total = 0;
  int bad = 0;

  uart_frame_tx #(.DIV_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tx_out(tx_out), .tx_empty(tx_empty), .buf_empty(buf_empty), .drop_flag(drop_flag));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int frame_len(input logic [5:0] fmt);
    return 1 + (fmt[1:0] + 5) + fmt[5] + (fmt[2] ? 2 : 1);
  endfunction

  function automatic logic exp_bit(input logic [7:0] d, input logic [5:0] fmt, input int k);
    int db = fmt[1:0] + 5;
    logic p = 1'b0;
    for (int i = 0; i < db; i++) p ^= d[i];
    if (k == 0) return 1'b0;
    if (k <= db) return d[k-1];
    if (fmt[5] && k == db + 1) return fmt[3] ? p : ~p;
    return 1'b1;
  endfunction

  task automatic wr(input logic [1:0] s, input logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_frame(input logic [7:0] d, input logic [5:0] fmt,
                           input logic [15:0] dv, input logic [2:0] fr, input bit inject);
    int p = 16 * dv + fr + 16;
    int n = frame_len(fmt);
    wr(2'd0, {10'd0, fmt});
    wr(2'd1, dv);
    wr(2'd2, {13'd0, fr});
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd3; wr_data = {8'd0, d};
    for (int m = 1; m <= n * p + 1; m++) begin
      @(negedge clk);
      if (m == 1) begin
        wr_en = 1'b0;
        chk(drop_flag == 1'b0, "R8 clear on accept", drop_flag, 0);
      end
      for (int k = 0; k < n; k++) begin
        if (m == k * p + p / 2 + 1) begin
          chk(tx_out == exp_bit(d, fmt, k),
              (k == 0) ? "R2 start" : (k <= fmt[1:0] + 5) ? "R2 data" :
              (fmt[5] && k == fmt[1:0] + 6) ? "R4 parity" : "R3 stop",
              tx_out, exp_bit(d, fmt, k));
          if (k == 0) chk(!tx_empty && !buf_empty, "R6 busy flags", {tx_empty, buf_empty}, 0);
        end
      end
      if (m == n * p) chk(!tx_empty && tx_out, "R5 last cycle", {tx_empty, tx_out}, 1);
      if (m == n * p + 1) chk(tx_empty && buf_empty && tx_out, "R6 idle after frame",
                              {tx_empty, buf_empty, tx_out}, 7);
      if (inject) begin
        if (m == 2 * p) begin
          wr_en = 1'b1; wr_sel = 2'd3; wr_data = {8'd0, ~d};
        end else if (m == 2 * p + 1) begin
          wr_sel = 2'd0; wr_data = {10'd0, fmt ^ 6'h2f};
        end else if (m == 2 * p + 2) begin
          wr_sel = 2'd1; wr_data = dv + 16'd2;
        end else if (m == 2 * p + 3) begin
          wr_en = 1'b0;
        end
      end
    end
    if (inject) chk(drop_flag == 1'b1, "R8 drop sticky, R9 frame intact", drop_flag, 1);
  endtask

  initial begin
    #(200000 * 8);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    #3;
    chk(tx_out && tx_empty && buf_empty && !drop_flag, "R1 async reset",
        {tx_out, tx_empty, buf_empty, drop_flag}, 4'he);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_out && tx_empty && buf_empty && !drop_flag, "R1 reset state",
        {tx_out, tx_empty, buf_empty, drop_flag}, 4'he);

    // R7: divisor zero refuses the byte
    wr(2'd1, 16'd0);
    wr(2'd3, 16'h00a5);
    begin
      bit ok = 1'b1;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (!tx_out || !tx_empty || !buf_empty) ok = 1'b0;
      end
      chk(ok, "R7 line idle with divisor zero", ok, 1);
      chk(drop_flag == 1'b1, "R7 drop with divisor zero", drop_flag, 1);
    end

    // directed corners (R10 select codes used throughout)
    run_frame(8'h00, 6'h00, 16'd1, 3'd0, 1'b0);
    run_frame(8'hff, 6'h2f, 16'd1, 3'd7, 1'b0);
    run_frame(8'hff, 6'h23, 16'd2, 3'd3, 1'b0);
    run_frame(8'h00, 6'h2b, 16'd1, 3'd1, 1'b0);
    run_frame(8'h00, 6'h27, 16'd1, 3'd5, 1'b0);
    run_frame(8'h5a, 6'h33, 16'd3, 3'd2, 1'b0);
    run_frame(8'h96, 6'h07, 16'd1, 3'd6, 1'b1);
    run_frame(8'h3c, 6'h2a, 16'd2, 3'd4, 1'b0);

    for (int t = 0; t < 20; t++) begin
      logic [7:0]  d   = 8'($urandom);
      logic [5:0]  fmt = 6'($urandom);
      logic [15:0] dv  = 16'($urandom_range(1, 3));
      logic [2:0]  fr  = 3'($urandom);
      run_frame(d, fmt, dv, fr, ($urandom_range(0, 3) == 0));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule